// File: doc/BRIEF.md
# SPI Transaction Command Sequencer

This block runs one SPI frame for each accepted command word. The command picks one of four chip selects and gives the frame length. It can also carry a receive-skip count, a transmit-only flag and a dual-output request. Between a transmit FIFO, a receive FIFO and a byte-level shifter, the sequencer decides three things for each byte: what is sent, whether transmit data is consumed, and whether the received byte is kept. Bit serialisation and serial clock generation are done elsewhere. The shifter takes a byte on a one-cycle start strobe and reports back with a one-cycle completion strobe that carries the received byte.

The block can do a write-then-read exchange without help. For the first "skip" bytes it sends command bytes taken from the transmit FIFO and throws away what comes back. After that it sends zeros of its own, stops reading the transmit FIFO, and keeps every byte it receives. Once the last byte completes, it releases chip select and raises a one-cycle done pulse.

Top module: `spi_frame_seq`

## Requirements
- R1: While idle, all chip-select outputs are high. After a command write is accepted, the `cs_n` line picked by command bits 31:30 goes low in the next cycle and stays low for the whole frame. All other `cs_n` lines stay high.
- R2: Command bits 15:0 hold the frame length minus one. A frame issues exactly that value plus one byte starts, so lengths from 1 to 65536 are possible.
- R3: When the skip count is zero and the transmit-only flag is clear, each byte sent is popped from the transmit FIFO in the same cycle as its start strobe. Each received byte is pushed to the receive FIFO in the cycle of its completion strobe.
- R4: Command bits 23:16 hold the skip count S. For byte positions 0 to S-1, data is popped from the transmit FIFO and sent, and the received bytes are not pushed.
- R5: From byte position S onward (when S is nonzero), the byte sent is 0x00, the transmit FIFO is not popped, and every received byte is pushed.
- R6: Command bit 28 (dual output) drives `sh_dual` high for the bytes of the receive phase only, and only when S is nonzero. With S equal to zero the bit is ignored and `sh_dual` stays low.
- R7: Command bit 27 (transmit only) makes every byte pop the transmit FIFO and no byte push the receive FIFO. The skip count is ignored in this mode.
- R8: `done` is high for exactly one cycle, in the cycle after the completion strobe of the last byte. In that same cycle `busy` is low and all `cs_n` lines are high.
- R9: If a byte needs transmit data and the transmit FIFO is empty, no start strobe is issued and chip select stays asserted until data arrives.
- R10: If a byte will be stored and the receive FIFO is full, no start strobe is issued until space frees up.
- R11: A command write while `busy` is high has no effect on the frame in progress or on the chip select.
- R12: At most one `cs_n` line is low at any time. No push happens while the receive FIFO is full, and no pop happens while the transmit FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 32 | Command word: [31:30] select, [28] dual, [27] tx-only, [23:16] skip, [15:0] length-1 |
| tx_avail | input | 1 | Transmit FIFO holds at least one byte |
| tx_data | input | 8 | Head byte of the transmit FIFO |
| tx_pop | output | 1 | Pop the transmit FIFO head |
| rx_full | input | 1 | Receive FIFO has no free entry |
| rx_push | output | 1 | Push `rx_data` into the receive FIFO |
| rx_data | output | 8 | Received byte to store |
| sh_start | output | 1 | Start strobe for one byte to the shifter |
| sh_txbyte | output | 8 | Byte to shift out, valid with `sh_start` |
| sh_dual | output | 1 | Use dual-line receive for this byte, valid with `sh_start` |
| sh_done | input | 1 | Shifter finished the current byte |
| sh_rxbyte | input | 8 | Byte received by the shifter, valid with `sh_done` |
| cs_n | output | 4 | Active-low chip selects |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle frame-complete pulse |

## Verification
Some properties are checked by assertions on every cycle: the single-active chip select, pops and pushes only against a ready FIFO, zero fill whenever a start strobe comes without a pop, the release of chip select together with the done pulse, and a command written during a frame leaving chip select unchanged. Other properties can only be shown by the bench scenarios, because they depend on the whole frame: exact byte counts for a given length field, where the skip boundary falls, dual output appearing only in the receive phase, transmit-only frames storing nothing, and the stalls that occur when the transmit FIFO is starved or the receive FIFO is full.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int CS_W   = 2;
  localparam int LEN_W  = 16;
  localparam int SKIP_W = 8;
  localparam int CMD_W  = 32;

  // Command word field positions
  localparam int CS_LSB   = 30;
  localparam int DUAL_BIT = 28;
  localparam int TXO_BIT  = 27;
  localparam int SKIP_LSB = 16;
  localparam int LEN_LSB  = 0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic [CS_W-1:0]   sel;
    logic              dual;
    logic              txonly;
    logic [SKIP_W-1:0] skip;
    logic [LEN_W-1:0]  last;
  } frame_cfg_t;
endpackage

// File: rtl/spi_seq_cmd.sv
module spi_seq_cmd
  import spi_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CMD_W-1:0] cmd_data,
  output frame_cfg_t       cfg
);
  frame_cfg_t cfg_d, cfg_q;

  always_comb begin
    cfg_d = cfg_q;
    if (load) begin
      cfg_d.sel    = cmd_data[CS_LSB +: CS_W];
      cfg_d.dual   = cmd_data[DUAL_BIT];
      cfg_d.txonly = cmd_data[TXO_BIT];
      cfg_d.skip   = cmd_data[SKIP_LSB +: SKIP_W];
      cfg_d.last   = cmd_data[LEN_LSB +: LEN_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/spi_seq_phase.sv
module spi_seq_phase
  import spi_seq_pkg::*;
(
  input  frame_cfg_t       cfg,
  input  logic [LEN_W-1:0] idx,
  output logic             need_tx,
  output logic             store,
  output logic             dual_out
);
  logic skip_mode;
  logic in_skip;

  always_comb begin
    skip_mode = (cfg.skip != '0);
    in_skip   = (idx < LEN_W'(cfg.skip));
    need_tx   = cfg.txonly | ~skip_mode | in_skip;
    store     = ~cfg.txonly & ~in_skip;
    dual_out  = cfg.dual & skip_mode & ~cfg.txonly & ~in_skip;
  end
endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [LEN_W-1:0] last,
  input  logic             need_tx,
  input  logic             store,
  input  logic             tx_avail,
  input  logic             rx_full,
  input  logic             sh_done,
  output logic             load,
  output logic             go,
  output logic             busy,
  output logic             done,
  output logic             byte_end,
  output logic [LEN_W-1:0] idx
);
  seq_state_t       state_q, state_d;
  logic [LEN_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    done_d   = 1'b0;
    load     = 1'b0;
    byte_end = 1'b0;
    go       = (state_q == ST_ISSUE) && (!need_tx || tx_avail) && (!store || !rx_full);
    case (state_q)
      ST_IDLE: if (cmd_wr) begin
        load    = 1'b1;
        idx_d   = '0;
        state_d = ST_ISSUE;
      end
      ST_ISSUE: if (go) state_d = ST_WAIT;
      ST_WAIT: if (sh_done) begin
        byte_end = 1'b1;
        if (idx_q == last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          idx_d   = idx_q + 1'b1;
          state_d = ST_ISSUE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;
  assign idx  = idx_q;

  // R9
  tx_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && need_tx && !tx_avail && state_q == ST_ISSUE) |=> busy);
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_CS = 1 << CS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic              tx_avail,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pop,
  input  logic              rx_full,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data,
  output logic              sh_start,
  output logic [DATA_W-1:0] sh_txbyte,
  output logic              sh_dual,
  input  logic              sh_done,
  input  logic [DATA_W-1:0] sh_rxbyte,
  output logic [NUM_CS-1:0] cs_n,
  output logic              busy,
  output logic              done
);
  frame_cfg_t       cfg;
  logic [LEN_W-1:0] idx;
  logic need_tx, store, dual_out, load, go, byte_end;

  spi_seq_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .load(load), .cmd_data(cmd_data), .cfg(cfg)
  );

  spi_seq_phase u_phase (
    .cfg(cfg), .idx(idx), .need_tx(need_tx), .store(store), .dual_out(dual_out)
  );

  spi_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .last(cfg.last),
    .need_tx(need_tx), .store(store), .tx_avail(tx_avail), .rx_full(rx_full),
    .sh_done(sh_done), .load(load), .go(go), .busy(busy), .done(done),
    .byte_end(byte_end), .idx(idx)
  );

  assign sh_start  = go;
  assign tx_pop    = go & need_tx;
  assign sh_txbyte = (go && need_tx) ? tx_data : '0;
  assign sh_dual   = go & dual_out;
  assign rx_push   = byte_end & store;
  assign rx_data   = sh_rxbyte;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = ~(busy && (cfg.sel == CS_W'(g)));
  end

  // R12
  onehot0_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n));
  // R12
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_push |-> !rx_full);
  // R12
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_pop |-> tx_avail);
  // R5
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_start && !tx_pop) |-> (sh_txbyte == '0));
  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (&cs_n && !busy));
  // R11
  busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr && !sh_done) |=> $stable(cs_n));
endmodule

// File: tb/spi_frame_seq_test.sv
module spi_frame_seq_test;
  logic clk = 0;
  logic rst_n = 0;
  logic cmd_wr = 0;
  logic [31:0] cmd_data = 0;
  logic tx_avail = 0, rx_full = 0, sh_done = 0;
  logic [7:0] tx_data = 0, sh_rxbyte = 0;
  logic tx_pop, rx_push, sh_start, sh_dual, busy, done;
  logic [7:0] rx_data, sh_txbyte;
  logic [3:0] cs_n;

  always #2 clk = ~clk;

  spi_frame_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .tx_avail(tx_avail), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data),
    .sh_start(sh_start), .sh_txbyte(sh_txbyte), .sh_dual(sh_dual),
    .sh_done(sh_done), .sh_rxbyte(sh_rxbyte),
    .cs_n(cs_n), .busy(busy), .done(done)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] txq[$], rxq[$], sentq[$];
  int rx_cap = 64;
  int sd_cnt = 0;
  logic [7:0] rx_seq = 8'hA0;
  int starts = 0, duals = 0;

  // behavioural reference state
  int m_st = 0;            // 0 idle, 1 waiting to launch, 2 byte in flight
  int m_idx = 0, m_last = 0, m_skip = 0, m_sel = 0;
  bit m_txo = 0, m_dual = 0, m_done = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic cycle();
    bit fetch, keep, go, e_pop, e_push, e_dual;
    logic [7:0] e_byte;
    logic [3:0] e_cs;
    tx_avail = (txq.size() > 0);
    tx_data  = (txq.size() > 0) ? txq[0] : 8'h00;
    rx_full  = (rxq.size() >= rx_cap);
    sh_done  = (sd_cnt == 1);
    sh_rxbyte = rx_seq;
    #1;
    fetch = m_txo || (m_skip == 0) || (m_idx < m_skip);
    keep  = !m_txo && !(m_idx < m_skip);
    go    = (m_st == 1) && (!fetch || txq.size() > 0) && (!keep || rxq.size() < rx_cap);
    e_pop  = go && fetch;
    e_push = (m_st == 2) && sh_done && keep;
    e_dual = go && m_dual && (m_skip != 0) && !m_txo && !(m_idx < m_skip);
    e_byte = fetch ? tx_data : 8'h00;
    e_cs   = (m_st != 0) ? ~(4'b1 << m_sel) : 4'hF;
    check("R1 cs_n", cs_n, e_cs);
    check("R2 sh_start", sh_start, go);
    check("R3 tx_pop", tx_pop, e_pop);
    check("R4 rx_push", rx_push, e_push);
    check("R6 sh_dual", sh_dual, e_dual);
    check("R8 done", done, m_done);
    check("R11 busy", busy, m_st != 0);
    if (go) check("R5 sh_txbyte", sh_txbyte, e_byte);
    if (e_push) check("R3 rx_data", rx_data, sh_rxbyte);
    // model update
    m_done = 0;
    if (e_pop) void'(txq.pop_front());
    if (e_push) rxq.push_back(sh_rxbyte);
    if (go) begin sentq.push_back(e_byte); starts++; if (e_dual) duals++; end
    if (sh_done) rx_seq++;
    if (sd_cnt > 0) sd_cnt--;
    if (go) sd_cnt = 3;
    case (m_st)
      0: if (cmd_wr) begin
        m_sel = cmd_data[31:30]; m_dual = cmd_data[28]; m_txo = cmd_data[27];
        m_skip = cmd_data[23:16]; m_last = cmd_data[15:0]; m_idx = 0; m_st = 1;
      end
      1: if (go) m_st = 2;
      default: if (sh_done) begin
        if (m_idx == m_last) begin m_st = 0; m_done = 1; end
        else begin m_idx++; m_st = 1; end
      end
    endcase
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
    @(negedge clk);
  endtask

  task automatic send_cmd(input int sel, input bit dual, input bit txo, input int skip, input int len1);
    cmd_data = {sel[1:0], 1'b0, dual, txo, 3'b0, skip[7:0], len1[15:0]};
    cmd_wr = 1;
    cycle();
    cmd_wr = 0;
  endtask

  task automatic run_idle();
    for (int k = 0; k < 2000 && (m_st != 0 || busy); k++) cycle();
    cycle();
  endtask

  task automatic reset_frame();
    rxq.delete(); sentq.delete(); starts = 0; duals = 0;
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 reset cs_n", cs_n, 4'hF);
    check("R8 reset done", done, 0);
    rst_n = 1;
    @(negedge clk);

    // normal frame, 4 bytes on select 1
    reset_frame();
    for (int i = 0; i < 4; i++) txq.push_back(8'h10 + i[7:0]);
    send_cmd(1, 0, 0, 0, 3);
    run_idle();
    check("R2 byte count", starts, 4);
    check("R3 stored count", rxq.size(), 4);
    for (int i = 0; i < 4; i++) check("R3 sent byte", sentq[i], 8'h10 + i);

    // write-then-read with dual: 2 command bytes, 4 read bytes
    reset_frame();
    txq.push_back(8'h9F); txq.push_back(8'h03);
    send_cmd(2, 1, 0, 2, 5);
    run_idle();
    check("R4 stored after skip", rxq.size(), 4);
    check("R4 first sent", sentq[0], 8'h9F);
    for (int i = 2; i < 6; i++) check("R5 zero fill", sentq[i], 0);
    check("R6 dual bytes", duals, 4);
    check("R5 tx untouched", txq.size(), 0);

    // dual requested with zero skip: ignored
    reset_frame();
    txq.push_back(8'h55); txq.push_back(8'h66);
    send_cmd(0, 1, 0, 0, 1);
    run_idle();
    check("R6 dual ignored", duals, 0);

    // tx-only, skip ignored
    reset_frame();
    for (int i = 0; i < 3; i++) txq.push_back(8'h30 + i[7:0]);
    send_cmd(3, 0, 1, 1, 2);
    run_idle();
    check("R7 nothing stored", rxq.size(), 0);
    check("R7 all popped", txq.size(), 0);

    // transmit starvation
    reset_frame();
    txq.push_back(8'h41);
    send_cmd(1, 0, 0, 0, 2);
    for (int k = 0; k < 20; k++) cycle();
    check("R9 one start only", starts, 1);
    check("R9 cs held", cs_n, 4'b1101);
    txq.push_back(8'h42); txq.push_back(8'h43);
    run_idle();
    check("R9 resumed", starts, 3);

    // receive FIFO full
    reset_frame();
    rx_cap = 1;
    for (int i = 0; i < 3; i++) txq.push_back(8'h50 + i[7:0]);
    send_cmd(0, 0, 0, 0, 2);
    for (int k = 0; k < 20; k++) cycle();
    check("R10 stalled on full", starts, 1);
    check("R10 busy", busy, 1);
    rx_cap = 64;
    run_idle();
    check("R10 resumed", starts, 3);

    // command during a frame is ignored
    reset_frame();
    for (int i = 0; i < 3; i++) txq.push_back(8'h60 + i[7:0]);
    send_cmd(2, 0, 0, 0, 2);
    for (int k = 0; k < 2; k++) cycle();
    send_cmd(0, 0, 0, 0, 9);
    check("R11 cs kept", cs_n, 4'b1011);
    run_idle();
    check("R11 length kept", starts, 3);

    // single-byte frame and skip longer than the frame
    reset_frame();
    txq.push_back(8'h77);
    send_cmd(3, 0, 0, 0, 0);
    run_idle();
    check("R2 single byte", starts, 1);
    reset_frame();
    txq.push_back(8'h01); txq.push_back(8'h02);
    send_cmd(1, 0, 0, 5, 1);
    run_idle();
    check("R4 skip beyond length", rxq.size(), 0);
    check("R8 idle at end", busy, 0);

    finish_run();
  end
endmodule